// File: doc/BRIEF.md
# Infrared Transceiver Receive-Width Mode Sequencer

This controller sits on the host side of an infrared transceiver. It owns two of the transceiver's pins, the shutdown line and the transmit line. When it is idle it holds shutdown low and passes the host's serial transmit bit straight through to the transmit pin.

On a programming request it runs a short timed sequence that selects the transceiver's receive output pulse width. First it raises shutdown and drives the transmit pin to the level that encodes the wanted width. It waits a setup interval and then drops shutdown, because the transceiver latches the transmit level on that falling edge. It then keeps the level for a hold interval before it hands the transmit pin back to the data path. A second request kind holds shutdown high for a long interval instead, which makes the transceiver fall back to its default short-pulse mode.

Every duration is counted in clock cycles and set by a parameter. A busy flag and a one-cycle done strobe let the caller sequence its requests.

Top module: `irx_mode_prog`

## Requirements
- R1: During and right after reset, sd_pin is 0, busy is 0 and done is 0, and tx_pin equals tx_data.
- R2: While idle, sd_pin is 0 and tx_pin follows tx_data in the same cycle.
- R3: A request (req_valid=1 with req_reset=0) seen at a rising clock edge makes sd_pin 1 for exactly SETUP_CYC cycles, starting with the next cycle. During that time tx_pin carries the mode level: 0 when req_long=1 (long 2 µs receive pulses) and 1 when req_long=0 (short 400 ns pulses).
- R4: After shutdown falls, tx_pin keeps the mode level for exactly HOLD_CYC cycles with sd_pin 0. During this time tx_data has no effect on tx_pin.
- R5: busy is 1 throughout a sequence. In the first cycle after a sequence ends, busy is 0 and done is 1 for exactly one cycle, and tx_pin again follows tx_data.
- R6: A request with req_reset=1 makes sd_pin 1 and tx_pin 0 for exactly RESET_CYC cycles, and then ends as in R5. req_reset takes priority over req_long.
- R7: A request that arrives while busy is 1 is ignored. The running sequence carries on unchanged and no new sequence follows it.
- R8: SETUP_CYC+HOLD_CYC must be below WINDOW_CYC, and this is checked at elaboration. A programming sequence stays busy for fewer than WINDOW_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start request, sampled at the clock edge |
| req_long | input | 1 | 1 selects long receive pulses, 0 selects short |
| req_reset | input | 1 | 1 requests the long shutdown fallback to default mode |
| tx_data | input | 1 | Serial transmit data from the host |
| sd_pin | output | 1 | Transceiver shutdown line |
| tx_pin | output | 1 | Transceiver transmit line |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle strobe when a sequence ends |

## Verification
The assertions check the following on every cycle. Shutdown never falls outside a sequence's setup-to-hold step or its final end. The transmit pin stays steady for as long as a sequence runs. Done lasts one cycle and comes only after busy. A programming sequence stays inside the window, and busy always starts with shutdown raised. The bench scenarios are needed to show the exact setup, hold and fallback lengths and the level encoding for each mode. They also show that data toggles are blocked during a sequence, that reset takes priority over the long-mode flag, and that requests made while busy leave no trace.

// File: rtl/irx_mode_pkg.sv
package irx_mode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HOLD  = 2'd2,
        ST_PURGE = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       lvl;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/irx_dwell_timer.sv
module irx_dwell_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/irx_pin_drive.sv
module irx_pin_drive
    import irx_mode_pkg::*;
(
    input  seq_state_e st,
    input  logic       lvl,
    input  logic       tx_data,
    output logic       sd_pin,
    output logic       tx_pin
);

    always_comb begin
        sd_pin = 1'b0;
        tx_pin = tx_data;
        case (st)
            ST_SETUP: begin sd_pin = 1'b1; tx_pin = lvl;  end
            ST_HOLD:  begin sd_pin = 1'b0; tx_pin = lvl;  end
            ST_PURGE: begin sd_pin = 1'b1; tx_pin = 1'b0; end
            default:  begin sd_pin = 1'b0; tx_pin = tx_data; end
        endcase
    end

endmodule

// File: rtl/irx_mode_prog.sv
module irx_mode_prog
    import irx_mode_pkg::*;
#(
    parameter int SETUP_CYC  = 4,
    parameter int HOLD_CYC   = 3,
    parameter int RESET_CYC  = 20,
    parameter int WINDOW_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_long,
    input  logic req_reset,
    input  logic tx_data,
    output logic sd_pin,
    output logic tx_pin,
    output logic busy,
    output logic done
);

    localparam int MAXC = (RESET_CYC > SETUP_CYC) ?
                          ((RESET_CYC > HOLD_CYC) ? RESET_CYC : HOLD_CYC) :
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam int WW   = $clog2(WINDOW_CYC + 1);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] RESET_LD = CW'(RESET_CYC - 1);

    if (SETUP_CYC < 1 || HOLD_CYC < 1 || RESET_CYC < 1) begin : g_bad_len
        $error("irx_mode_prog: every duration needs at least one cycle");
    end
    if (SETUP_CYC + HOLD_CYC >= WINDOW_CYC) begin : g_bad_window
        $error("irx_mode_prog: setup plus hold does not fit the window"); // R8
    end

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic [WW-1:0] win_d, win_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = SETUP_LD;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_reset) begin
                        r_d.st  = ST_PURGE;
                        r_d.lvl = 1'b0;
                        tmr_val = RESET_LD;
                    end else begin
                        r_d.st  = ST_SETUP;
                        r_d.lvl = ~req_long;
                        tmr_val = SETUP_LD;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.st   = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_HOLD, ST_PURGE: begin
                if (tmr_expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (r_q.st == ST_SETUP || r_q.st == ST_HOLD)
            win_d = win_q + 1'b1;
        else
            win_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '{st: ST_IDLE, lvl: 1'b0, done: 1'b0};
            win_q <= '0;
        end else begin
            r_q   <= r_d;
            win_q <= win_d;
        end
    end

    irx_dwell_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    irx_pin_drive u_pins (
        .st      (r_q.st),
        .lvl     (r_q.lvl),
        .tx_data (tx_data),
        .sd_pin  (sd_pin),
        .tx_pin  (tx_pin)
    );

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;

    AST_BUSY_STARTS_SD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sd_pin); // R3
    AST_SD_FALL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_pin) |-> (busy || done)); // R4
    AST_TX_STEADY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tx_pin)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R5
    AST_IDLE_SD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !sd_pin); // R2
    AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        win_q < WW'(WINDOW_CYC)); // R8

endmodule

// File: tb/irx_mode_prog_test.sv
module irx_mode_prog_test;

    localparam int CLK_PERIOD = 10;
    localparam int S  = 4;
    localparam int H  = 3;
    localparam int RC = 20;
    localparam int W  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_long = 1'b0, req_reset = 1'b0, tx_data = 1'b0;
    logic sd_pin, tx_pin, busy, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    irx_mode_prog #(.SETUP_CYC(S), .HOLD_CYC(H), .RESET_CYC(RC), .WINDOW_CYC(W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_long(req_long),
        .req_reset(req_reset), .tx_data(tx_data), .sd_pin(sd_pin), .tx_pin(tx_pin),
        .busy(busy), .done(done)
    );

    typedef struct {
        logic  sd;
        logic  tx;
        logic  bz;
        logic  dn;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   ended  = 1'b0;

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if ({sd_pin, tx_pin, busy, done} !== {e.sd, e.tx, e.bz, e.dn}) begin
                n_fail++;
                $display("FAIL %s: sd/tx/busy/done actual %b%b%b%b expected %b%b%b%b",
                         e.req, sd_pin, tx_pin, busy, done, e.sd, e.tx, e.bz, e.dn);
            end
        end
    end

    task automatic drive(input logic rv, rl, rr, td,
                         input logic esd, etx, ebz, edn, input string r);
        exp_t e;
        req_valid = rv; req_long = rl; req_reset = rr; tx_data = td;
        e.sd = esd; e.tx = etx; e.bz = ebz; e.dn = edn; e.req = r;
        q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic prog(input logic lng, input bit poke);
        logic lvl;
        lvl = ~lng;
        drive(1, lng, 0, 1, 0, 1, 0, 0, "R2");
        for (int i = 0; i < S; i++) begin
            if (poke && i == 1) drive(1, ~lng, 1, 1, 1, lvl, 1, 0, "R7");
            else                drive(0, 0, 0, i[0], 1, lvl, 1, 0, "R3");
        end
        for (int i = 0; i < H; i++) begin
            if (poke && i == 0) drive(1, lng, 0, ~lvl, 0, lvl, 1, 0, "R7");
            else                drive(0, 0, 0, ~i[0], 0, lvl, 1, 0, "R4");
        end
        drive(0, 0, 0, 1, 0, 1, 0, 1, "R5");
        drive(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    endtask

    task automatic purge(input logic lng);
        drive(1, lng, 1, 1, 0, 1, 0, 0, "R2");
        for (int i = 0; i < RC; i++)
            drive(0, 0, 0, i[0], 1, 0, 1, 0, "R6");
        drive(0, 0, 0, 1, 0, 1, 0, 1, "R6");
        drive(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tx_data = 1'b1;
        #(CLK_PERIOD*2 + 2);
        n_chk++;
        if ({sd_pin, tx_pin, busy, done} !== 4'b0100) begin
            n_fail++;
            $display("FAIL R1: in reset actual %b%b%b%b expected 0100", sd_pin, tx_pin, busy, done);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        drive(0, 0, 0, 1, 0, 1, 0, 0, "R1");
        drive(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        drive(0, 1, 0, 1, 0, 1, 0, 0, "R2");
        drive(0, 0, 1, 0, 0, 0, 0, 0, "R2");
        prog(1'b1, 1'b0);
        prog(1'b0, 1'b0);
        prog(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) drive(0, 0, 0, i[0], 0, i[0], 0, 0, "R7");
        purge(1'b1);
        purge(1'b0);
        prog(1'b0, 1'b1);
        drive(0, 0, 0, 1, 0, 1, 0, 0, "R8");
        @(negedge clk); #1;
        finish_run();
    end

endmodule